// File: doc/BRIEF.md
# Interlaced Vertical Blanking Window Generator

This block decides, line by line, when an interlaced video encoder shows active picture and when it blanks. It keeps a frame line counter that restarts at zero on the leading edge of the vertical sync that opens the odd field. Each line-start strobe advances the counter. The counter is compared against two programmable line numbers. The blank-start line marks where blanking begins and where incoming pixels stop being taken. The blank-end line marks where active video resumes and pixels are accepted again. Both numbers apply as written in the odd field. The even field uses the same numbers shifted by a fixed amount: 262 lines for the 525-line standard and 313 lines for the 625-line standard.

A host writes the two line numbers through a small register port. The values wait in a pending copy and move into the working copy only at the next odd-field sync, so a window that is already running is never cut short. In progressive-input mode, the input side takes one non-interlaced frame per output frame. Its accept window then follows only the unshifted numbers, while output blanking still follows both fields. When the blank output is switched off, the block drives no blanking and always accepts pixels.

Each window is kept by its own copy of a three-state machine. The states are W_OFF (window disabled), W_OPEN (active video or accepting) and W_SHUT (blanked or ignoring). The transitions are: enable_drop (any state to W_OFF when the blank output is disabled), arm (W_OFF to W_OPEN when it is enabled), close (W_OPEN to W_SHUT on a start hit with no end hit) and reopen (W_SHUT to W_OPEN on an end hit).

Top module: `vblank_window_gen`

## Requirements
- R1: After reset, blank is 0 and pix_in_en is 1. The working blank-start line is 259 (low byte 03h, high bit 1) and the working blank-end line is 19 (13h).
- R2: A vsync_stb sets the line counter to 0. Otherwise each line_stb adds 1. vsync_stb wins when both strobes arrive in the same cycle. The counter holds at 1023 and never wraps back to 0.
- R3: A write at address 0 sets bits 7:0 of the blank-start line. A write at address 1 sets bit 8 from data bit 0. A write at address 2 sets the 8-bit blank-end line. A write at address 3 has no effect.
- R4: blank rises one clock after the counter equals the blank-start line S. It falls one clock after the counter equals the blank-end line E. The window may wrap through line 0.
- R5: Blanking also starts one clock after the counter equals S+K and ends one clock after it equals E+K. K is 262 when std_625 is 0 and 313 when std_625 is 1.
- R6: If a start hit and an end hit occur in the same cycle, the end hit wins: blank goes to 0 or stays at 0.
- R7: A register write changes only the pending copy. The pending copy moves to the working copy on the next vsync_stb. A write in the same cycle as vsync_stb waits for the following vsync_stb.
- R8: With prog_mode at 0 and blank_out_en at 1, pix_in_en equals the inverse of blank.
- R9: With prog_mode at 1, pix_in_en goes low one clock after the counter equals S and high one clock after it equals E. The shifted lines are not used for pix_in_en. blank still follows R4 and R5.
- R10: While blank_out_en is 0, blank is 0 and pix_in_en is 1 in the same cycle. After blank_out_en returns to 1, both windows stay open until the next start hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register address (0 start low, 1 start high, 2 end) |
| reg_wr_data | input | 8 | Register write data |
| line_stb | input | 1 | One-cycle pulse at each line start |
| vsync_stb | input | 1 | One-cycle pulse at the leading edge of the odd-field vsync |
| std_625 | input | 1 | 1 selects the 625-line standard, 0 selects 525 |
| prog_mode | input | 1 | 1 selects progressive input framing |
| blank_out_en | input | 1 | 1 when the blank pin is an output |
| blank | output | 1 | Vertical blanking flag |
| pix_in_en | output | 1 | Pixel input accept flag |

## Verification
A counter that is off by one line moves every blank edge by one line start. A window machine stuck in the wrong state inverts blank and pix_in_en until the next start or end hit. Either fault therefore appears at the ports within one frame at most. A working register loaded too early changes the edge positions inside the same frame as the write, rather than one vsync later. The bench's clock-by-clock reference model shows this at the first affected line.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
    typedef enum logic [1:0] {
        W_OFF  = 2'd0,
        W_OPEN = 2'd1,
        W_SHUT = 2'd2
    } win_state_t;

    localparam int unsigned ADDR_START_LO = 0;
    localparam int unsigned ADDR_START_HI = 1;
    localparam int unsigned ADDR_END      = 2;
endpackage

// File: rtl/vbw_line_counter.sv
module vbw_line_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_stb,
    input  logic             line_stb,
    output logic [CNT_W-1:0] line_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (vsync_stb) begin
            line_cnt <= '0;
        end else if (line_stb && (line_cnt != CNT_MAX)) begin
            line_cnt <= line_cnt + CNT_W'(1);
        end
    end

    // R2: sync restarts the count
    p_sync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_stb |=> (line_cnt == '0));

    // R2: a line strobe steps the count unless it is saturated
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !vsync_stb && (line_cnt != CNT_MAX)) |=> (line_cnt == $past(line_cnt) + CNT_W'(1)));

    // R2: saturation, never wraps to zero without sync
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_stb && (line_cnt == CNT_MAX)) |=> (line_cnt == CNT_MAX));
endmodule

// File: rtl/vbw_shadow_regs.sv
module vbw_shadow_regs
    import vbw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned START_RST = 259,
    parameter int unsigned END_RST   = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W:0]   start_line,
    output logic [DATA_W-1:0] end_line
);
    localparam int unsigned START_W = DATA_W + 1;

    logic [START_W-1:0] pend_start;
    logic [DATA_W-1:0]  pend_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start <= START_W'(START_RST);
            pend_end   <= DATA_W'(END_RST);
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_START_LO)) begin
                pend_start[DATA_W-1:0] <= wr_data;
            end else if (wr_addr == ADDR_W'(ADDR_START_HI)) begin
                pend_start[DATA_W] <= wr_data[0];
            end else if (wr_addr == ADDR_W'(ADDR_END)) begin
                pend_end <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_line <= START_W'(START_RST);
            end_line   <= DATA_W'(END_RST);
        end else if (load) begin
            start_line <= pend_start;
            end_line   <= pend_end;
        end
    end

    // R7: working copy moves only on the field sync
    p_hold_between_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(start_line) && $stable(end_line)));
endmodule

// File: rtl/vbw_window_fsm.sv
module vbw_window_fsm
    import vbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_hit,
    input  logic end_hit,
    output logic shut
);
    win_state_t state_q;
    win_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = W_OFF;                                  // enable_drop
        end else begin
            unique case (state_q)
                W_OFF:   state_d = W_OPEN;                    // arm
                W_OPEN:  if (start_hit && !end_hit) state_d = W_SHUT; // close
                W_SHUT:  if (end_hit) state_d = W_OPEN;       // reopen
                default: state_d = W_OFF;
            endcase
        end
    end

    always_comb begin
        shut = (state_q == W_SHUT);
    end

    // R4: the window only closes after a start hit
    p_close_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut) |-> ($past(start_hit) && $past(enable)));

    // R6: an end hit never leaves the window shut
    p_end_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit |=> !shut);
endmodule

// File: rtl/vblank_window_gen.sv
module vblank_window_gen
    import vbw_pkg::*;
#(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned OFF_525   = 262,
    parameter int unsigned OFF_625   = 313,
    parameter int unsigned START_RST = 259,
    parameter int unsigned END_RST   = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              line_stb,
    input  logic              vsync_stb,
    input  logic              std_625,
    input  logic              prog_mode,
    input  logic              blank_out_en,
    output logic              blank,
    output logic              pix_in_en
);
    localparam int unsigned N_WIN  = 2;
    localparam int unsigned WIN_OUT = 0;
    localparam int unsigned WIN_IN  = 1;

    logic [CNT_W-1:0]  line_cnt;
    logic [DATA_W:0]   start_line;
    logic [DATA_W-1:0] end_line;
    logic [CNT_W-1:0]  fld_off;
    logic [CNT_W-1:0]  start_odd, end_odd, start_even, end_even;
    logic [N_WIN-1:0]  start_hit, end_hit, win_shut;

    vbw_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_stb (vsync_stb),
        .line_stb  (line_stb),
        .line_cnt  (line_cnt)
    );

    vbw_shadow_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .START_RST (START_RST),
        .END_RST   (END_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .load       (vsync_stb),
        .start_line (start_line),
        .end_line   (end_line)
    );

    always_comb begin
        fld_off    = std_625 ? CNT_W'(OFF_625) : CNT_W'(OFF_525);
        start_odd  = CNT_W'(start_line);
        end_odd    = CNT_W'(end_line);
        start_even = start_odd + fld_off;
        end_even   = end_odd + fld_off;
    end

    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            if (w == WIN_OUT) begin : g_both_fields
                assign start_hit[w] = (line_cnt == start_odd) || (line_cnt == start_even);
                assign end_hit[w]   = (line_cnt == end_odd)   || (line_cnt == end_even);
            end else begin : g_odd_only
                assign start_hit[w] = (line_cnt == start_odd);
                assign end_hit[w]   = (line_cnt == end_odd);
            end

            vbw_window_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .enable    (blank_out_en),
                .start_hit (start_hit[w]),
                .end_hit   (end_hit[w]),
                .shut      (win_shut[w])
            );
        end
    endgenerate

    always_comb begin
        blank = blank_out_en && win_shut[WIN_OUT];
        if (!blank_out_en) begin
            pix_in_en = 1'b1;
        end else if (prog_mode) begin
            pix_in_en = !win_shut[WIN_IN];
        end else begin
            pix_in_en = !win_shut[WIN_OUT];
        end
    end

    // R8: interlaced input never accepts pixels while blanked
    p_blank_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !prog_mode) |-> !pix_in_en);

    // R5: no blank rise without a matching line on either field
    p_rise_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(blank) && $past(blank_out_en) && blank_out_en) |->
            ($past(line_cnt) == $past(start_odd) || $past(line_cnt) == $past(start_even)));
endmodule

// File: tb/test_vblank_window_gen.sv
`timescale 1ns/1ps
module test_vblank_window_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic       line_stb = 1'b0;
    logic       vsync_stb = 1'b0;
    logic       std_625 = 1'b0;
    logic       prog_mode = 1'b0;
    logic       blank_out_en = 1'b1;
    logic       blank;
    logic       pix_in_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    vblank_window_gen i_vblank_window_gen (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .line_stb(line_stb), .vsync_stb(vsync_stb), .std_625(std_625),
        .prog_mode(prog_mode), .blank_out_en(blank_out_en),
        .blank(blank), .pix_in_en(pix_in_en)
    );

    // reference model: 0 off, 1 open, 2 shut
    int m_cnt, m_ps, m_pe, m_as, m_ae, m_out, m_in;

    always @(posedge clk) begin
        int k;
        bit sh, eh, sho, eho;
        if (!rst_n) begin
            m_cnt = 0; m_ps = 259; m_pe = 19; m_as = 259; m_ae = 19;
            m_out = 1; m_in = 1;
        end else begin
            k = std_625 ? 313 : 262;
            sh  = (m_cnt == m_as) || (m_cnt == m_as + k);
            eh  = (m_cnt == m_ae) || (m_cnt == m_ae + k);
            sho = (m_cnt == m_as);
            eho = (m_cnt == m_ae);
            if (!blank_out_en) m_out = 0;
            else if (m_out == 0) m_out = 1;
            else if (m_out == 1 && sh && !eh) m_out = 2;
            else if (m_out == 2 && eh) m_out = 1;
            if (!blank_out_en) m_in = 0;
            else if (m_in == 0) m_in = 1;
            else if (m_in == 1 && sho && !eho) m_in = 2;
            else if (m_in == 2 && eho) m_in = 1;
            if (vsync_stb) m_cnt = 0;
            else if (line_stb && m_cnt < 1023) m_cnt = m_cnt + 1;
            if (vsync_stb) begin m_as = m_ps; m_ae = m_pe; end
            if (reg_wr_en) begin
                if (reg_wr_addr == 2'd0) m_ps = (m_ps & 256) | reg_wr_data;
                else if (reg_wr_addr == 2'd1) m_ps = (m_ps & 255) | (reg_wr_data[0] ? 256 : 0);
                else if (reg_wr_addr == 2'd2) m_pe = reg_wr_data;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic eb, ep;
        #1;
        if (rst_n && !done) begin
            eb = blank_out_en && (m_out == 2);
            if (!blank_out_en) ep = 1'b1;
            else if (prog_mode) ep = (m_in != 2);
            else ep = (m_out != 2);
            check(tag, blank, eb, "blank");
            check(tag, pix_in_en, ep, "pix_in_en");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic vsync();
        @(negedge clk); vsync_stb = 1'b1;
        @(negedge clk); vsync_stb = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_stb = 1'b1;
            @(negedge clk); line_stb = 1'b0;
        end
    endtask

    task automatic frame(input int n);
        vsync();
        lines(n - 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check("R1", blank, 1'b0, "reset blank");
        check("R1", pix_in_en, 1'b1, "reset pix_in_en");
        // R4 R5 R8: default window, 525 lines
        tag = "R4";
        frame(525);
        tag = "R5";
        frame(525);
        // R2: strobes together, vsync wins
        tag = "R2";
        @(negedge clk); vsync_stb = 1'b1; line_stb = 1'b1;
        @(negedge clk); vsync_stb = 1'b0; line_stb = 1'b0;
        lines(524);
        // R3 R7: write mid frame, takes effect after next vsync
        tag = "R7";
        vsync();
        lines(100);
        wr(2'd0, 8'd40);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd90);
        wr(2'd3, 8'd5);
        lines(424);
        tag = "R3";
        frame(525);
        // R7: write in the same cycle as vsync waits one more frame
        tag = "R7";
        @(negedge clk);
        vsync_stb = 1'b1; reg_wr_en = 1'b1; reg_wr_addr = 2'd2; reg_wr_data = 8'd60;
        @(negedge clk);
        vsync_stb = 1'b0; reg_wr_en = 1'b0;
        lines(524);
        frame(525);
        // R5: 625 standard with wrapping window
        tag = "R5";
        std_625 = 1'b1;
        wr(2'd0, 8'd44);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'd22);
        frame(625);
        frame(625);
        // R9: progressive input gating
        tag = "R9";
        prog_mode = 1'b1;
        frame(625);
        frame(625);
        prog_mode = 1'b0;
        // R6: start equals end
        tag = "R6";
        wr(2'd0, 8'd30);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd30);
        frame(625);
        frame(625);
        // R10: blank output disabled then re-enabled mid frame
        tag = "R10";
        wr(2'd2, 8'd120);
        vsync();
        lines(50);
        blank_out_en = 1'b0;
        lines(200);
        @(negedge clk);
        check("R10", blank, 1'b0, "disabled blank");
        check("R10", pix_in_en, 1'b1, "disabled pix_in_en");
        blank_out_en = 1'b1;
        lines(374);
        frame(625);
        // R2: counter saturates without sync
        tag = "R2";
        std_625 = 1'b0;
        wr(2'd0, 8'd5);
        wr(2'd2, 8'd10);
        frame(525);
        lines(1200);
        @(negedge clk);
        check("R2", blank, 1'b0, "saturated count no rewrap");
        // R8: interlaced relation on a fresh frame
        tag = "R8";
        frame(525);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule